// File: doc/BRIEF.md
# Serially Configured Lookup-Table Logic Fabric

This block is a tiny programmable logic array built from eight identical slices. Each slice evaluates one 3-input boolean function from an 8-entry truth table and drives its result onto one line of a shared 8-line bus. The three inputs of every slice are chosen by 4-bit routing codes. A code can pick any bus line, one of four external pins, or a constant zero. One option bit per slice makes the bus line either follow the lookup result directly or take it from a flip-flop clocked by the fabric clock. The registered option lets the fabric hold counters, pulse-width comparators and small state machines.

All configuration state sits in one long serial shift chain. A host shifts a new image in one bit per clock while the shift enable is high. The slices keep running on the image they were given last. When the enable drops, the whole staged image is copied into the live configuration in a single cycle, and a one-cycle done pulse follows. A reset clears only the slice output flip-flops. Both the staged and the live configuration survive it.

Top module: `lut_fabric_top`

## Requirements
- R1: A slice's lookup result is truth-table entry k, where k = {c,b,a} is formed from its three selected inputs (a is bit 0, c is bit 2).
- R2: Routing code 0–7 selects bus line 0–7, code 8–11 selects ext_in bit 0–3, and code 12–15 supplies constant 0.
- R3: While cfg_shift_en is high, the chain shifts by one bit per clock and cfg_din enters at the near end. The image is sent slice 0 first and slice 7 last. Each slice's 21 bits are sent in this order: table entries 7 down to 0, then the c code (MSB first), then the b code, then the a code, then the registered-output bit (1 = registered). cfg_dout is the far end of the chain, which holds the first bit sent. While cfg_shift_en is low, the chain holds.
- R4: The live configuration is unchanged while cfg_shift_en is high. It takes the staged image on the first clock at which cfg_shift_en is sampled low after being high. cfg_done is high for exactly the one cycle that follows that clock.
- R5: With the registered bit set, bus line i shows a flip-flop that loads slice i's lookup result on every clock.
- R6: Driving rst_n low clears all slice flip-flops and cfg_done at once, without waiting for a clock. Release takes effect through a 2-stage synchronizer. Reset leaves the staged chain and the live configuration unchanged.
- R7: When slice i selects bus line j with j < i, it sees that line's current value. When j >= i, it sees slice j's flip-flop, which holds slice j's lookup result from the previous clock whatever slice j's option bit is.
- R8: With the registered bit clear, bus line i follows slice i's lookup result combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric and configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_din | input | 1 | Serial configuration data |
| cfg_shift_en | input | 1 | Shift enable for the configuration chain |
| ext_in | input | 4 | External inputs available to routing codes 8–11 |
| cfg_dout | output | 1 | Far end of the configuration chain |
| cfg_done | output | 1 | One-cycle pulse after a new image goes live |
| bus_out | output | 8 | Shared slice output bus |

## Verification
The hardest case to reach is a slice running with registered state while a new image is being shifted in. The live logic has to stay untouched until the exact clock on which the enable falls. The bench gets there by first loading a counter image and running it with a varying count enable. It then starts a second load and, about 100 bits in, checks that the bus still matches the counter's frozen state. After that it checks that the second image's combinational functions appear in the cycle after the enable drops. A reset asserted in the middle of a count shows the asynchronous clear on the bus. The counter resuming afterwards shows that the configuration survived the reset.

// File: rtl/lut_fabric_pkg.sv
`timescale 1ns/1ps
package lut_fabric_pkg;
  localparam int LUT_K       = 3;
  localparam int LUT_ENTRIES = 1 << LUT_K;
  localparam int ROUTE_W     = 4;

  // Field order here fixes the serial order: truth table first, then
  // route[2] (c), route[1] (b), route[0] (a), then the register option.
  typedef struct packed {
    logic [LUT_ENTRIES-1:0]          truth;
    logic [LUT_K-1:0][ROUTE_W-1:0]   route;
    logic                            use_reg;
  } slice_cfg_t;

  localparam int SLICE_CFG_W = $bits(slice_cfg_t);
endpackage

// File: rtl/lut_rst_sync.sv
`timescale 1ns/1ps
module lut_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) pipe_q <= '0;
    else              pipe_q <= pipe_d;
  end

  assign rst_n_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/lut_cfg_cell.sv
`timescale 1ns/1ps
module lut_cfg_cell
  import lut_fabric_pkg::*;
(
  input  logic                   clk,
  input  logic                   shift_en,
  input  logic                   apply,
  input  logic                   ser_in,
  output logic                   ser_out,
  output logic [SLICE_CFG_W-1:0] staged_bits,
  output slice_cfg_t             live_cfg
);
  localparam int W = SLICE_CFG_W;

  logic [W-1:0] chain_q, chain_d;
  slice_cfg_t   live_q,  live_d;

  // Staged segment: shifts only under the enable, no reset on purpose.
  always_comb begin
    chain_d = chain_q;
    if (shift_en) chain_d = {chain_q[W-2:0], ser_in};
  end

  always_ff @(posedge clk) begin
    chain_q <= chain_d;
  end

  // Live copy: loaded in one cycle when the host finishes shifting.
  always_comb begin
    live_d = live_q;
    if (apply) live_d = slice_cfg_t'(chain_q);
  end

  always_ff @(posedge clk) begin
    live_q <= live_d;
  end

  assign ser_out     = chain_q[W-1];
  assign staged_bits = chain_q;
  assign live_cfg    = live_q;
endmodule

// File: rtl/lut_eval.sv
`timescale 1ns/1ps
module lut_eval
  import lut_fabric_pkg::*;
#(
  parameter int N   = 8,
  parameter int EXT = 4
) (
  input  slice_cfg_t [N-1:0] cfg,
  input  logic [EXT-1:0]     ext,
  input  logic [N-1:0]       reg_q,
  output logic [N-1:0]       bus,
  output logic [N-1:0]       lut_val
);
  logic [N-1:0]       view;
  logic [LUT_K-1:0]   idx;
  logic               res;

  function automatic logic pick(input logic [ROUTE_W-1:0] code,
                                input logic [N-1:0]       lines,
                                input logic [EXT-1:0]     pins);
    logic v;
    v = 1'b0;
    for (int j = 0; j < N; j++)
      if (code == ROUTE_W'(j)) v = lines[j];
    for (int e = 0; e < EXT; e++)
      if (code == ROUTE_W'(N + e)) v = pins[e];
    return v;
  endfunction

  // Slices are evaluated in index order. Lines at or above the current
  // index are seen through their flip-flops, so no loop can form.
  always_comb begin
    view    = reg_q;
    lut_val = '0;
    idx     = '0;
    res     = 1'b0;
    for (int i = 0; i < N; i++) begin
      for (int k = 0; k < LUT_K; k++)
        idx[k] = pick(cfg[i].route[k], view, ext);
      res        = cfg[i].truth[idx];
      lut_val[i] = res;
      view[i]    = cfg[i].use_reg ? reg_q[i] : res;
    end
    bus = view;
  end
endmodule

// File: rtl/lut_fabric_top.sv
`timescale 1ns/1ps
module lut_fabric_top
  import lut_fabric_pkg::*;
#(
  parameter int NUM_SLICES = 8,
  parameter int NUM_EXT    = 4,
  parameter int RST_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_din,
  input  logic                  cfg_shift_en,
  input  logic [NUM_EXT-1:0]    ext_in,
  output logic                  cfg_dout,
  output logic                  cfg_done,
  output logic [NUM_SLICES-1:0] bus_out
);
  localparam int SEG_W   = SLICE_CFG_W;
  localparam int CHAIN_W = NUM_SLICES * SEG_W;

  logic rst_n_s;
  logic cfg_en_q, cfg_en_d;
  logic done_q,   done_d;
  logic apply;

  logic [NUM_SLICES:0]             link;
  logic [CHAIN_W-1:0]              chain_flat;
  slice_cfg_t [NUM_SLICES-1:0]     act_cfg;
  logic [NUM_SLICES*SEG_W-1:0]     act_flat;
  logic [NUM_SLICES-1:0]           reg_q, reg_d, lut_val, bus_w;

  lut_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_s)
  );

  // Commit detection: enable seen high last clock, low now.
  assign apply = cfg_en_q & ~cfg_shift_en;

  always_comb begin
    cfg_en_d = cfg_shift_en;
    done_d   = apply;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cfg_en_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      cfg_en_q <= cfg_en_d;
      done_q   <= done_d;
    end
  end

  // Chain enters at the highest slice and leaves from slice 0.
  assign link[NUM_SLICES] = cfg_din;

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_cell
    logic [SEG_W-1:0] seg;
    lut_cfg_cell cell_i (
      .clk         (clk),
      .shift_en    (cfg_shift_en),
      .apply       (apply),
      .ser_in      (link[i+1]),
      .ser_out     (link[i]),
      .staged_bits (seg),
      .live_cfg    (act_cfg[i])
    );
    assign chain_flat[CHAIN_W-1-i*SEG_W -: SEG_W] = seg;
  end

  assign act_flat = act_cfg;

  lut_eval #(.N(NUM_SLICES), .EXT(NUM_EXT)) eval_i (
    .cfg     (act_cfg),
    .ext     (ext_in),
    .reg_q   (reg_q),
    .bus     (bus_w),
    .lut_val (lut_val)
  );

  // Slice flip-flops load every clock; only reset touches them otherwise.
  always_comb begin
    reg_d = lut_val;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) reg_q <= '0;
    else          reg_q <= reg_d;
  end

  assign cfg_dout = link[0];
  assign cfg_done = done_q;
  assign bus_out  = bus_w;
endmodule

// File: rtl/lut_fabric_chk.sv
`timescale 1ns/1ps
module lut_fabric_chk #(
  parameter int N       = 8,
  parameter int SEG_W   = 21,
  parameter int CHAIN_W = 168
) (
  input logic               clk,
  input logic               rst_n_s,
  input logic               cfg_din,
  input logic               cfg_shift_en,
  input logic               cfg_done,
  input logic [CHAIN_W-1:0] chain_flat,
  input logic [N*SEG_W-1:0] act_flat,
  input logic [N-1:0]       reg_q,
  input logic [N-1:0]       bus_out
);
  // R3: one-bit shift per enabled clock, new bit at the near end
  assert_chain_shift_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    cfg_shift_en |=> chain_flat == {$past(chain_flat[CHAIN_W-2:0]), $past(cfg_din)});

  // R3 / R6: chain holds whenever not shifting
  assert_chain_hold_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cfg_shift_en |=> $stable(chain_flat));

  // R4: live configuration frozen during shifting
  assert_live_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    cfg_shift_en |=> $stable(act_flat));

  // R4: done only follows a falling enable
  assert_done_cause_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    cfg_done |-> ($past(cfg_shift_en, 2) && !$past(cfg_shift_en)));

  // R4: done lasts one cycle
  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    cfg_done |=> !cfg_done);

  // R6: flip-flops are clear when reset releases
  assert_reset_clear_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> reg_q == '0);

  for (genvar i = 0; i < N; i++) begin : g_line
    // R5: registered slices show their flip-flop on the bus
    assert_reg_line_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
      act_flat[i*SEG_W] |-> bus_out[i] == reg_q[i]);
  end
endmodule

bind lut_fabric_top lut_fabric_chk #(
  .N(NUM_SLICES), .SEG_W(SEG_W), .CHAIN_W(CHAIN_W)
) chk_i (
  .clk          (clk),
  .rst_n_s      (rst_n_s),
  .cfg_din      (cfg_din),
  .cfg_shift_en (cfg_shift_en),
  .cfg_done     (cfg_done),
  .chain_flat   (chain_flat),
  .act_flat     (act_flat),
  .reg_q        (reg_q),
  .bus_out      (bus_out)
);

// File: tb/lut_fabric_top_tb_top.sv
`timescale 1ns/1ps
module lut_fabric_top_tb_top;
  localparam int NS       = 8;
  localparam int NE       = 4;
  localparam int SEGW     = 21;
  localparam int STREAM_W = NS * SEGW;

  // {ext_in, expected bus} for the all-combinational image
  localparam logic [11:0] A_VEC [0:7] = '{
    12'h0_28, 12'h1_3A, 12'h7_BF, 12'h8_24,
    12'hF_A7, 12'h6_A8, 12'hB_A4, 12'h5_38
  };

  logic          clk;
  logic          rst_n;
  logic          cfg_din;
  logic          cfg_shift_en;
  logic [NE-1:0] ext_in;
  logic          cfg_dout;
  logic          cfg_done;
  logic [NS-1:0] bus_out;

  int checks   = 0;
  int failures = 0;

  logic [7:0] t_lut [NS];
  logic [3:0] t_rc  [NS];
  logic [3:0] t_rb  [NS];
  logic [3:0] t_ra  [NS];
  logic       t_reg [NS];

  logic [2:0] cnt;
  logic       prev_e3;

  lut_fabric_top dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_din      (cfg_din),
    .cfg_shift_en (cfg_shift_en),
    .ext_in       (ext_in),
    .cfg_dout     (cfg_dout),
    .cfg_done     (cfg_done),
    .bus_out      (bus_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic set_slice(input int s, input logic [7:0] t,
                           input logic [3:0] c, input logic [3:0] b,
                           input logic [3:0] a, input logic r);
    t_lut[s] = t; t_rc[s] = c; t_rb[s] = b; t_ra[s] = a; t_reg[s] = r;
  endtask

  // R3 ordering: slice 0 first; per slice table 7..0, c, b, a (MSB first), option
  task automatic load_config(input int mid_bit, input logic [7:0] mid_exp);
    logic [STREAM_W-1:0] stream;
    int pos;
    pos = STREAM_W - 1;
    for (int s = 0; s < NS; s++) begin
      for (int k = 7; k >= 0; k--) begin stream[pos] = t_lut[s][k]; pos--; end
      for (int k = 3; k >= 0; k--) begin stream[pos] = t_rc[s][k];  pos--; end
      for (int k = 3; k >= 0; k--) begin stream[pos] = t_rb[s][k];  pos--; end
      for (int k = 3; k >= 0; k--) begin stream[pos] = t_ra[s][k];  pos--; end
      stream[pos] = t_reg[s]; pos--;
    end
    for (int n = 0; n < STREAM_W; n++) begin
      @(negedge clk);
      cfg_shift_en = 1'b1;
      cfg_din      = stream[STREAM_W-1-n];
      if (n == mid_bit) begin
        #1 check("R4", "bus unchanged mid-shift", bus_out, mid_exp);
      end
    end
    @(negedge clk);
    cfg_shift_en = 1'b0;
    cfg_din      = 1'b0;
    #1 check("R4", "done low before commit", {7'd0, cfg_done}, 8'd0);
    @(negedge clk);
    #1 check("R4", "done pulse after commit", {7'd0, cfg_done}, 8'd1);
    check("R3", "chain tail holds first bit", {7'd0, cfg_dout},
          {7'd0, stream[STREAM_W-1]});
    @(negedge clk);
    #1 check("R4", "done single cycle", {7'd0, cfg_done}, 8'd0);
  endtask

  function automatic logic [7:0] exp_b(input logic [2:0] c, input logic e0,
                                       input logic e3, input logic p);
    logic [7:0] v;
    v[0] = c[0];
    v[1] = c[0] & e0;
    v[2] = c[1];
    v[3] = c[1] & c[0] & e0;
    v[4] = c[2];
    v[5] = ~c[2] & ~c[1];
    v[6] = p;
    v[7] = e3;
    return v;
  endfunction

  task automatic step_b(input logic e0, input logic e3, input string req);
    @(negedge clk);
    ext_in = {e3, 2'b00, e0};
    #1 check(req, "counter image bus", bus_out, exp_b(cnt, e0, e3, prev_e3));
    @(posedge clk);
    if (e0) cnt = cnt + 3'd1;
    prev_e3 = e3;
  endtask

  task automatic image_a();
    set_slice(0, 8'h80, 4'd10, 4'd9,  4'd8,  1'b0); // AND of ext 0..2
    set_slice(1, 8'h96, 4'd10, 4'd9,  4'd8,  1'b0); // XOR of ext 0..2
    set_slice(2, 8'h0E, 4'd12, 4'd11, 4'd0,  1'b0); // line0 | ext3
    set_slice(3, 8'h01, 4'd12, 4'd12, 4'd11, 1'b0); // ~ext3
    set_slice(4, 8'hCA, 4'd8,  4'd3,  4'd1,  1'b0); // ext0 ? line3 : line1
    set_slice(5, 8'hFF, 4'd12, 4'd12, 4'd12, 1'b0); // constant 1
    set_slice(6, 8'hFE, 4'd15, 4'd14, 4'd13, 1'b0); // constant-zero codes
    set_slice(7, 8'hAA, 4'd12, 4'd12, 4'd9,  1'b0); // buffer ext1
  endtask

  task automatic image_b();
    set_slice(0, 8'h66, 4'd12, 4'd8,  4'd0,  1'b1); // q0 ^= en
    set_slice(1, 8'h08, 4'd12, 4'd8,  4'd0,  1'b0); // carry q0 & en
    set_slice(2, 8'h66, 4'd12, 4'd1,  4'd2,  1'b1); // q1 ^= carry
    set_slice(3, 8'h08, 4'd12, 4'd1,  4'd2,  1'b0); // carry
    set_slice(4, 8'h66, 4'd12, 4'd3,  4'd4,  1'b1); // q2 ^= carry
    set_slice(5, 8'h01, 4'd12, 4'd2,  4'd4,  1'b0); // count < 2
    set_slice(6, 8'hAA, 4'd12, 4'd12, 4'd7,  1'b0); // forward read of line 7
    set_slice(7, 8'hAA, 4'd12, 4'd12, 4'd11, 1'b0); // buffer ext3
  endtask

  task automatic hold_reset_release();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cfg_din = 1'b0; cfg_shift_en = 1'b0; ext_in = '0;
    cnt = 3'd0; prev_e3 = 1'b0;
    repeat (3) @(negedge clk);
    #1 check("R6", "done low in reset", {7'd0, cfg_done}, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Combinational image: R1 R2 R7 R8 through the vector table
    image_a();
    load_config(-1, 8'h00);
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      ext_in = A_VEC[v][11:8];
      #1 check("R1_R2_R8", "combinational image", bus_out, A_VEC[v][7:0]);
    end

    // Counter image, then reset to clear flip-flops (config must survive)
    @(negedge clk);
    ext_in = '0;
    image_b();
    load_config(-1, 8'h00);
    hold_reset_release();
    cnt = 3'd0; prev_e3 = 1'b0;
    check("R6", "chain kept across reset", {7'd0, cfg_dout}, 8'd0);
    for (int t = 0; t < 24; t++)
      step_b((t % 5) != 3, t[1], "R5_R7");

    // Asynchronous reset in the middle of a count
    @(negedge clk);
    ext_in = 4'b0001;
    rst_n  = 1'b0;
    cnt = 3'd0; prev_e3 = 1'b0;
    #1 check("R6", "async clear of flip-flops", bus_out,
             exp_b(3'd0, 1'b1, 1'b0, 1'b0));
    @(negedge clk);
    ext_in = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int t = 0; t < 10; t++)
      step_b(1'b1, t[0], "R6");

    // Shift a new image while the counter holds; live logic must not change
    @(negedge clk);
    ext_in = '0;
    @(posedge clk);
    prev_e3 = 1'b0;
    image_a();
    load_config(100, exp_b(cnt, 1'b0, 1'b0, 1'b0));
    for (int v = 0; v < 3; v++) begin
      @(negedge clk);
      ext_in = A_VEC[v+2][11:8];
      #1 check("R4", "new image live after commit", bus_out, A_VEC[v+2][7:0]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule